// File: doc/BRIEF.md
# Tick-Driven 32-bit Countdown Timer

This block is a general-purpose down-counter whose 32-bit count is split across two 16-bit host registers, a low half and a high half. It decrements by one on each cycle where the external tick-enable pulse is high. Typically that pulse is a 5 MHz strobe divided down from the system clock. The host starts and stops counting by writing one-shot command bits to a third register.

When a tick arrives with the count at zero, the count wraps to all ones and counting continues. One cycle later the block raises a single-cycle underflow flag, which an interrupt collector outside the block can capture.

Writing either count half replaces that half at once, so the countdown resumes from the new value. Reading the low half also copies the current high half into a shadow register. A later read of the high half returns that shadow, so a 32-bit value read as two halves always belongs to a single moment.

Top module: `tick_timer`

## Requirements
- R1: After reset the count and the shadow are zero, the timer is stopped, the underflow flag is low, and a read of the command register returns 0x0002 (bit 1 = stopped, bit 0 = running).
- R2: While running, each cycle with `tickEn` high decrements the 32-bit count {high, low} by exactly one. Cycles without `tickEn` leave it unchanged.
- R3: A command write with bit 1 (stop) set stops the timer. While it is stopped, ticks leave the count frozen.
- R4: A tick that reaches a running count of zero sets the count to 0xFFFFFFFF. `underflowPulse` is then high for exactly the following cycle, and the timer keeps running.
- R5: While the timer is stopped, no tick produces an underflow pulse, even with the count at zero.
- R6: A write to address 0 replaces the low half and a write to address 1 replaces the high half. The other half is kept, and counting continues from the written value.
- R7: A write to address 0, 1 or 2 in the same cycle as a tick consumes that tick: the count is not decremented in that cycle.
- R8: Reading address 0 returns the live low half and latches the live high half. Reading address 1 returns the latched high half.
- R9: A command write with bit 0 (start) set and bit 1 clear starts the timer. When both bits are set, stop wins.
- R10: Address 3 reads as zero and ignores writes. `regRdData` is zero whenever `regRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select: 0 low half, 1 high half, 2 command |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, combinational from address and state |
| tickEn | input | 1 | Single-cycle count-enable pulse |
| underflowPulse | output | 1 | One-cycle flag after the count wraps from zero |

## Verification
Two functions can fall in the same cycle: a host write to a count or command register, and a tick pulse. The bench drives both in one cycle, with a low-half write while running and a stop command while running. A reference model applies the rule that the write consumes the tick, and the register values read back afterwards are compared against it. The other collision is a low-half read that lands on a ticking cycle. There the bench checks that the latched high half matches the value from before the edge, not the decremented one.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic decrement;
    logic latchHi;
  } tmrStrobes_t;

  localparam int ADDR_LO        = 0;
  localparam int ADDR_HI        = 1;
  localparam int ADDR_CMD       = 2;
  localparam int CMD_START_BIT  = 0;
  localparam int CMD_STOP_BIT   = 1;

endpackage

// File: rtl/tick_timer_ctl.sv
module tick_timer_ctl
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [HALF_W-1:0] regWrData,
  input  logic              tickEn,
  input  logic [HALF_W-1:0] countLo,
  input  logic [HALF_W-1:0] shadowHi,
  output tmrStrobes_t       strobes,
  output logic              running,
  output logic [HALF_W-1:0] regRdData
);

  logic hitLo, hitHi, hitCmd;
  logic countWrite, cmdWrite;
  logic [HALF_W-1:0] statusWord;

  always_comb begin
    hitLo      = (regAddr == ADDR_W'(ADDR_LO));
    hitHi      = (regAddr == ADDR_W'(ADDR_HI));
    hitCmd     = (regAddr == ADDR_W'(ADDR_CMD));
    countWrite = regWrEn && (hitLo || hitHi);
    cmdWrite   = regWrEn && hitCmd;
    strobes.loadLo    = regWrEn && hitLo;
    strobes.loadHi    = regWrEn && hitHi;
    strobes.decrement = tickEn && running && !countWrite && !cmdWrite;
    strobes.latchHi   = regRdEn && hitLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (cmdWrite) begin
      if (regWrData[CMD_STOP_BIT])       running <= 1'b0;
      else if (regWrData[CMD_START_BIT]) running <= 1'b1;
    end
  end

  always_comb begin
    statusWord                = '0;
    statusWord[CMD_START_BIT] = running;
    statusWord[CMD_STOP_BIT]  = !running;
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      if (hitLo)       regRdData = countLo;
      else if (hitHi)  regRdData = shadowHi;
      else if (hitCmd) regRdData = statusWord;
    end
  end

  // R9: stop bit in a command write always leaves the timer stopped
  a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && regWrData[CMD_STOP_BIT]) |=> !running);

  // R9: start alone leaves the timer running
  a_r9_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && regWrData[CMD_START_BIT] && !regWrData[CMD_STOP_BIT]) |=> running);

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strobes,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] countLo,
  output logic [HALF_W-1:0] shadowHi,
  output logic              underflowPulse
);

  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] count;
  logic             anyLoad;

  assign anyLoad = strobes.loadLo || strobes.loadHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count          <= '0;
      shadowHi       <= '0;
      underflowPulse <= 1'b0;
    end else begin
      underflowPulse <= strobes.decrement && (count == '0);
      if (strobes.latchHi) shadowHi <= count[CNT_W-1:HALF_W];
      if (anyLoad) begin
        if (strobes.loadLo) count[HALF_W-1:0]     <= wrData;
        if (strobes.loadHi) count[CNT_W-1:HALF_W] <= wrData;
      end else if (strobes.decrement) begin
        count <= count - 1'b1;
      end
    end
  end

  assign countLo = count[HALF_W-1:0];

  // R3: without a load or a decrement strobe the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(anyLoad || strobes.decrement) |=> $stable(count));

  // R4: a decrement at zero wraps to all ones and flags underflow
  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decrement && (count == '0)) |=> ((count == '1) && underflowPulse));

  // R4: the underflow flag lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    underflowPulse |=> !underflowPulse);

  // R6: a low-half write lands as written
  a_r6_load_lo: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLo |=> (count[HALF_W-1:0] == $past(wrData)));

  // R8: the shadow captures the high half seen on the read cycle
  a_r8_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchHi |=> (shadowHi == $past(count[CNT_W-1:HALF_W])));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [HALF_W-1:0] regWrData,
  output logic [HALF_W-1:0] regRdData,
  input  logic              tickEn,
  output logic              underflowPulse
);

  tmrStrobes_t       strobes;
  logic              running;
  logic [HALF_W-1:0] countLo;
  logic [HALF_W-1:0] shadowHi;

  tick_timer_ctl #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .tickEn    (tickEn),
    .countLo   (countLo),
    .shadowHi  (shadowHi),
    .strobes   (strobes),
    .running   (running),
    .regRdData (regRdData)
  );

  tick_timer_dp #(.HALF_W(HALF_W)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .wrData         (regWrData),
    .countLo        (countLo),
    .shadowHi       (shadowHi),
    .underflowPulse (underflowPulse)
  );

  // R5: no underflow flag can follow a cycle in which the timer was stopped
  a_r5_no_flag_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> !underflowPulse);

endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/100ps
module tick_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        tickEn = 1'b0;
  logic        underflowPulse;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  logic [31:0] mCount = '0;
  logic [15:0] mShadow = '0;
  logic        mRun = 1'b0;
  logic        mPulse = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .tickEn(tickEn), .underflowPulse(underflowPulse)
  );

  // Behavioural reference model, updated on each rising edge
  always @(posedge clk) begin
    logic [31:0] oldCount;
    logic wrCnt, wrCmd;
    if (!rstN) begin
      mCount = '0; mShadow = '0; mRun = 1'b0; mPulse = 1'b0;
    end else begin
      oldCount = mCount;
      mPulse = 1'b0;
      wrCnt = regWrEn && (regAddr == 2'd0 || regAddr == 2'd1);
      wrCmd = regWrEn && (regAddr == 2'd2);
      if (regRdEn && regAddr == 2'd0) mShadow = oldCount[31:16];
      if (tickEn && mRun && !wrCnt && !wrCmd) begin
        if (oldCount == 32'd0) mPulse = 1'b1;
        mCount = oldCount - 32'd1;
      end
      if (regWrEn) begin
        case (regAddr)
          2'd0: mCount[15:0] = regWrData;
          2'd1: mCount[31:16] = regWrData;
          2'd2: if (regWrData[1]) mRun = 1'b0; else if (regWrData[0]) mRun = 1'b1;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] expRead();
    if (!regRdEn) return 16'h0;
    case (regAddr)
      2'd0: return mCount[15:0];
      2'd1: return mShadow;
      2'd2: return {14'h0, !mRun, mRun};
      default: return 16'h0;
    endcase
  endfunction

  // Compare every cycle, away from the active edge
  always begin
    @(negedge clk);
    #1;
    checks++;
    if (underflowPulse !== mPulse) begin
      failures++;
      $display("FAIL %s underflowPulse actual=%0b expected=%0b", curReq, underflowPulse, mPulse);
    end
    checks++;
    if (regRdData !== expRead()) begin
      failures++;
      $display("FAIL %s regRdData addr=%0d actual=%h expected=%h", curReq, regAddr, regRdData, expRead());
    end
  end

  task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [15:0] d, input logic tk);
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = d; tickEn = tk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 16'h0, 1'b0);
  endtask

  task automatic readAll();
    step(1'b0, 1'b1, 2'd0, 16'h0, 1'b0);
    step(1'b0, 1'b1, 2'd1, 16'h0, 1'b0);
    step(1'b0, 1'b1, 2'd2, 16'h0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    readAll();                            // reset values, stopped status
    rstN = 1'b1;
    readAll();

    curReq = "R10";
    step(1'b1, 1'b0, 2'd3, 16'hBEEF, 1'b0);
    step(1'b0, 1'b1, 2'd3, 16'h0, 1'b0);
    readAll();

    curReq = "R6";
    step(1'b1, 1'b0, 2'd0, 16'h0005, 1'b0);
    step(1'b1, 1'b0, 2'd1, 16'h0001, 1'b0);
    readAll();

    curReq = "R2";
    step(1'b1, 1'b0, 2'd2, 16'h0001, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1);
      idle(2);
    end
    readAll();

    curReq = "R8";
    step(1'b1, 1'b0, 2'd0, 16'h0000, 1'b0);
    step(1'b1, 1'b0, 2'd1, 16'h0002, 1'b0);
    step(1'b0, 1'b1, 2'd0, 16'h0, 1'b0);  // latch high = 2
    step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1);  // borrow into high half
    step(1'b0, 1'b1, 2'd1, 16'h0, 1'b0);  // still shadow 2
    step(1'b0, 1'b1, 2'd0, 16'h0, 1'b1);  // read during tick latches pre-edge high
    step(1'b0, 1'b1, 2'd1, 16'h0, 1'b0);

    curReq = "R3";
    step(1'b1, 1'b0, 2'd2, 16'h0002, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1);
    readAll();

    curReq = "R4";
    step(1'b1, 1'b0, 2'd0, 16'h0000, 1'b0);
    step(1'b1, 1'b0, 2'd1, 16'h0000, 1'b0);
    step(1'b1, 1'b0, 2'd2, 16'h0001, 1'b0);
    step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1);  // wrap from zero
    idle(2);
    readAll();
    step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1);  // continues running
    readAll();

    curReq = "R5";
    step(1'b1, 1'b0, 2'd2, 16'h0002, 1'b0);
    step(1'b1, 1'b0, 2'd0, 16'h0000, 1'b0);
    step(1'b1, 1'b0, 2'd1, 16'h0000, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1);
    idle(2);
    readAll();

    curReq = "R7";
    step(1'b1, 1'b0, 2'd1, 16'h0000, 1'b0);
    step(1'b1, 1'b0, 2'd0, 16'h0010, 1'b0);
    step(1'b1, 1'b0, 2'd2, 16'h0001, 1'b1);
    step(1'b1, 1'b0, 2'd0, 16'h0020, 1'b1);  // write consumes tick
    readAll();
    step(1'b1, 1'b0, 2'd1, 16'h0003, 1'b1);
    readAll();
    step(1'b1, 1'b0, 2'd2, 16'h0002, 1'b1);  // stop consumes tick
    readAll();

    curReq = "R9";
    step(1'b1, 1'b0, 2'd2, 16'h0001, 1'b0);
    readAll();
    step(1'b1, 1'b0, 2'd2, 16'h0003, 1'b0);  // both bits: stop wins
    readAll();
    step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1);
    readAll();

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule